// File: doc/BRIEF.md
# Charge Pump Mode Selector

This block holds the digital mode logic of a capacitor step-up converter that feeds two card supply rails. Each card asks for its rail to be off, at 3 V or at 5 V, and the converter has to cover the higher of the two requests. The block combines that request with two pairs of supply comparator flags. From these it picks how the pump runs: passing the supply straight through (follower), doubling it or tripling it. It also picks a code for the regulation setpoint that the analog loop should hold.

Each comparator threshold arrives as two flags, one for the upper and one for the lower switch point. The block keeps a band state that changes only when the supply crosses the far point, which gives the hysteresis. A new selection only reaches the registered outputs after it has held for a set number of clock cycles. A short disturbance on the request or comparator inputs therefore never switches the pump. When both cards are off, the pump is disabled and reports the idle code.

Top module: `pump_mode_sel`

## Requirements
- R1: Request codes per card are 0 = off, 1 = 3 V, 2 = 5 V, and code 3 is treated as 5 V. The effective target is the higher of the two cards' requests.
- R2: With both cards off, the outputs are mode code 0 (idle), target code 0 (none) and pump enable 0. Pump enable is 1 for every other mode.
- R3: With the supply in the low band and a 3 V target, the outputs are mode code 2 (doubler) and target code 1 (about 4.0 V).
- R4: With the supply in the low band and a 5 V target, the outputs are mode code 3 (tripler) and target code 2 (about 5.5 V).
- R5: With the supply in the middle or high band and a 3 V target, the outputs are mode code 1 (follower) and target code 0.
- R6: With the supply in the middle band and a 5 V target, the outputs are mode code 2 (doubler) and target code 2.
- R7: With the supply in the high band and a 5 V target, the outputs are mode code 1 (follower) and target code 0.
- R8: The supply leaves the low band when the 3.5 V rising flag is 1. It returns to the low band only when the 3.4 V falling flag is 0. With the rising flag 0 and the falling flag 1, the band is held.
- R9: The supply enters the high band when the 5.9 V rising flag is 1. It leaves the high band only when the 5.8 V falling flag is 0. With the rising flag 0 and the falling flag 1, the band is held.
- R10: When the inputs change to a new selection, the outputs are unchanged for STABLE_CYCLES+1 rising edges and show the new selection after rising edge STABLE_CYCLES+2.
- R11: A selection that lasts fewer than STABLE_CYCLES clock cycles at the inputs never reaches the outputs.
- R12: Synchronous reset gives idle mode, target code 0, pump enable 0 and the low supply band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| card_a_req | input | 2 | Supply request of card A |
| card_b_req | input | 2 | Supply request of card B |
| sup_gt_lo_rise | input | 1 | Supply above the 3.5 V upper switch point |
| sup_gt_lo_fall | input | 1 | Supply above the 3.4 V lower switch point |
| sup_gt_hi_rise | input | 1 | Supply above the 5.9 V upper switch point |
| sup_gt_hi_fall | input | 1 | Supply above the 5.8 V lower switch point |
| pump_mode_o | output | 2 | Pump mode: 0 idle, 1 follower, 2 doubler, 3 tripler |
| reg_target_o | output | 2 | Regulation target: 0 none, 1 about 4.0 V, 2 about 5.5 V |
| pump_en_o | output | 1 | Pump enabled |

## Verification
The hardest state to reach from the ports is a supply sitting inside a hysteresis gap. In that state, one flag of a pair is set and the other is clear, and the result depends on how the supply got there. The stimulus first drives both flags of a pair to settle a band. It then opens the gap from each side and checks that the mode stays put. The debounce window is tested in two ways: the output is sampled on the edge just before the expected change and on the edge of the change, and a request pulse one cycle shorter than the window is applied.

// File: rtl/pump_mode_pkg.sv
package pump_mode_pkg;

  typedef enum logic [1:0] {
    PM_IDLE   = 2'd0,
    PM_FOLLOW = 2'd1,
    PM_DOUBLE = 2'd2,
    PM_TRIPLE = 2'd3
  } pump_mode_e;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_LOW  = 2'd1,
    TG_HIGH = 2'd2,
    TG_RSVD = 2'd3
  } reg_tgt_e;

  typedef struct packed {
    pump_mode_e mode;
    reg_tgt_e   tgt;
  } pump_sel_t;

  localparam int REQ_W = 2;

  // Rank of a request: 0 off, 1 low rail, 2 high rail (code 3 ranks as high).
  function automatic logic [1:0] req_rank(input logic [REQ_W-1:0] code);
    case (code)
      2'd0:    req_rank = 2'd0;
      2'd1:    req_rank = 2'd1;
      default: req_rank = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/band_hyst.sv
module band_hyst #(
  parameter int NUM_BANDS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANDS-1:0] above_rise,
  input  logic [NUM_BANDS-1:0] above_fall,
  output logic [NUM_BANDS-1:0] band_q
);

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    always_ff @(posedge clk) begin
      if (rst)                band_q[g] <= 1'b0;
      else if (above_rise[g]) band_q[g] <= 1'b1;
      else if (!above_fall[g]) band_q[g] <= 1'b0;
    end

    // band 0 covers R8, band 1 covers R9
    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!above_rise[g] && above_fall[g]) |=> $stable(band_q[g])); // R8
    AST_BAND_DROP: assert property (@(posedge clk) disable iff (rst)
      (!above_rise[g] && !above_fall[g]) |=> !band_q[g]); // R9
    AST_BAND_RISE: assert property (@(posedge clk) disable iff (rst)
      above_rise[g] |=> band_q[g]); // R8
  end

endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import pump_mode_pkg::*;
(
  input  logic [REQ_W-1:0] req_a,
  input  logic [REQ_W-1:0] req_b,
  input  logic             band_mid,
  input  logic             band_high,
  output pump_sel_t        sel
);

  logic [1:0] rank_a, rank_b, rank_max;

  always_comb begin
    rank_a   = req_rank(req_a);
    rank_b   = req_rank(req_b);
    rank_max = (rank_a > rank_b) ? rank_a : rank_b;

    sel.mode = PM_IDLE;
    sel.tgt  = TG_NONE;
    case (rank_max)
      2'd1: begin
        if (band_mid || band_high) begin
          sel.mode = PM_FOLLOW;
          sel.tgt  = TG_NONE;
        end else begin
          sel.mode = PM_DOUBLE;
          sel.tgt  = TG_LOW;
        end
      end
      2'd2: begin
        if (band_high) begin
          sel.mode = PM_FOLLOW;
          sel.tgt  = TG_NONE;
        end else if (band_mid) begin
          sel.mode = PM_DOUBLE;
          sel.tgt  = TG_HIGH;
        end else begin
          sel.mode = PM_TRIPLE;
          sel.tgt  = TG_HIGH;
        end
      end
      default: begin
        sel.mode = PM_IDLE;
        sel.tgt  = TG_NONE;
      end
    endcase
  end

endmodule

// File: rtl/sel_filter.sv
module sel_filter
  import pump_mode_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  pump_sel_t sel_i,
  output pump_sel_t sel_o
);

  localparam int CNT_MAX = (STABLE_CYCLES > 1) ? STABLE_CYCLES - 1 : 0;
  localparam int CNT_W   = (CNT_MAX > 0) ? $clog2(CNT_MAX + 1) : 1;

  pump_sel_t        cand_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      cnt_q  <= '0;
      sel_o  <= '0;
    end else if (sel_i != cand_q) begin
      cand_q <= sel_i;
      cnt_q  <= '0;
    end else if (cnt_q != CNT_W'(CNT_MAX)) begin
      cnt_q  <= cnt_q + 1'b1;
    end else begin
      sel_o  <= cand_q;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX)); // R10
  AST_COMMIT_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> ($past(cnt_q) == CNT_W'(CNT_MAX) && $past(sel_i) == $past(cand_q))); // R10
  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (sel_i != cand_q) |=> (cnt_q == '0 && $stable(sel_o))); // R11

endmodule

// File: rtl/pump_mode_sel.sv
module pump_mode_sel
  import pump_mode_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] card_a_req,
  input  logic [REQ_W-1:0] card_b_req,
  input  logic             sup_gt_lo_rise,
  input  logic             sup_gt_lo_fall,
  input  logic             sup_gt_hi_rise,
  input  logic             sup_gt_hi_fall,
  output logic [1:0]       pump_mode_o,
  output logic [1:0]       reg_target_o,
  output logic             pump_en_o
);

  localparam int NUM_BANDS = 2;

  logic [REQ_W-1:0]     req_a_q, req_b_q;
  logic [NUM_BANDS-1:0] band_q;
  pump_sel_t            sel_raw, sel_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_a_q <= '0;
      req_b_q <= '0;
    end else begin
      req_a_q <= card_a_req;
      req_b_q <= card_b_req;
    end
  end

  band_hyst #(.NUM_BANDS(NUM_BANDS)) u_band (
    .clk        (clk),
    .rst        (rst),
    .above_rise ({sup_gt_hi_rise, sup_gt_lo_rise}),
    .above_fall ({sup_gt_hi_fall, sup_gt_lo_fall}),
    .band_q     (band_q)
  );

  mode_decode u_decode (
    .req_a     (req_a_q),
    .req_b     (req_b_q),
    .band_mid  (band_q[0]),
    .band_high (band_q[1]),
    .sel       (sel_raw)
  );

  sel_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .sel_i (sel_raw),
    .sel_o (sel_out)
  );

  assign pump_mode_o  = sel_out.mode;
  assign reg_target_o = sel_out.tgt;
  assign pump_en_o    = (sel_out.mode != PM_IDLE);

  AST_FOLLOW_NO_TGT: assert property (@(posedge clk) disable iff (rst)
    (pump_mode_o == PM_FOLLOW) |-> (reg_target_o == TG_NONE)); // R5
  AST_TRIPLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pump_mode_o == PM_TRIPLE) |-> (reg_target_o == TG_HIGH)); // R4
  AST_IDLE_NO_TGT: assert property (@(posedge clk) disable iff (rst)
    (pump_mode_o == PM_IDLE) |-> (reg_target_o == TG_NONE && !pump_en_o)); // R2
  AST_NO_RSVD_TGT: assert property (@(posedge clk) disable iff (rst)
    reg_target_o != TG_RSVD); // R3

endmodule

// File: tb/pump_mode_sel_tb_top.sv
module pump_mode_sel_tb_top;

  localparam int STABLE = 4;
  localparam int NVEC   = 12;
  localparam int SETTLE = STABLE + 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] req_a = '0, req_b = '0;
  logic       lo_r = 1'b0, lo_f = 1'b0, hi_r = 1'b0, hi_f = 1'b0;
  logic [1:0] mode, tgt;
  logic       en;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pump_mode_sel #(.STABLE_CYCLES(STABLE)) dut_i (
    .clk(clk), .rst(rst),
    .card_a_req(req_a), .card_b_req(req_b),
    .sup_gt_lo_rise(lo_r), .sup_gt_lo_fall(lo_f),
    .sup_gt_hi_rise(hi_r), .sup_gt_hi_fall(hi_f),
    .pump_mode_o(mode), .reg_target_o(tgt), .pump_en_o(en)
  );

  // [15:12] requirement, [11:10] card A, [9:8] card B,
  // [7:4] flags lo_rise lo_fall hi_rise hi_fall, [3:2] mode, [1:0] target
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd2, 2'd0, 2'd0, 4'b0000, 2'd0, 2'd0},  // R2 both off
    {4'd3, 2'd1, 2'd0, 4'b0000, 2'd2, 2'd1},  // R3
    {4'd4, 2'd0, 2'd2, 4'b0000, 2'd3, 2'd2},  // R4
    {4'd1, 2'd1, 2'd2, 4'b0000, 2'd3, 2'd2},  // R1 higher request wins
    {4'd1, 2'd3, 2'd0, 4'b0000, 2'd3, 2'd2},  // R1 code 3 as 5 V
    {4'd5, 2'd1, 2'd1, 4'b1100, 2'd1, 2'd0},  // R5
    {4'd6, 2'd2, 2'd1, 4'b1100, 2'd2, 2'd2},  // R6
    {4'd7, 2'd2, 2'd2, 4'b1111, 2'd1, 2'd0},  // R7
    {4'd5, 2'd1, 2'd0, 4'b1111, 2'd1, 2'd0},  // R5 high band
    {4'd2, 2'd0, 2'd0, 4'b1111, 2'd0, 2'd0},  // R2
    {4'd4, 2'd0, 2'd3, 4'b0000, 2'd3, 2'd2},  // R4
    {4'd6, 2'd2, 2'd0, 4'b1100, 2'd2, 2'd2}   // R6
  };

  task automatic check(input logic [1:0] em, input logic [1:0] et, input string rq);
    vectors++;
    if (mode !== em || tgt !== et || en !== (em != 2'd0)) begin
      miscompares++;
      $display("FAIL %s: mode=%0d tgt=%0d en=%0b expected mode=%0d tgt=%0d en=%0b",
               rq, mode, tgt, en, em, et, (em != 2'd0));
    end
  endtask

  task automatic set_flags(input logic [3:0] f);
    {lo_r, lo_f, hi_r, hi_f} = f;
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(2'd0, 2'd0, "R12 reset");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {req_a, req_b} = VEC[i][11:8];
      set_flags(VEC[i][7:4]);
      settle();
      check(VEC[i][3:2], VEC[i][1:0], $sformatf("R%0d vec%0d", VEC[i][15:12], i));
    end

    // R8 lower hysteresis, 5 V target
    req_a = 2'd2; req_b = 2'd0; set_flags(4'b1100); settle();
    check(2'd2, 2'd2, "R8 mid band");
    set_flags(4'b0100); settle();
    check(2'd2, 2'd2, "R8 hold in gap from above");
    set_flags(4'b0000); settle();
    check(2'd3, 2'd2, "R8 drop to low band");
    set_flags(4'b0100); settle();
    check(2'd3, 2'd2, "R8 hold in gap from below");

    // R9 upper hysteresis
    set_flags(4'b1111); settle();
    check(2'd1, 2'd0, "R9 high band");
    set_flags(4'b1101); settle();
    check(2'd1, 2'd0, "R9 hold in gap from above");
    set_flags(4'b1100); settle();
    check(2'd2, 2'd2, "R9 leave high band");
    set_flags(4'b1101); settle();
    check(2'd2, 2'd2, "R9 hold in gap from below");

    // R10 latency: doubler -> idle
    req_a = 2'd0; req_b = 2'd0;
    repeat (STABLE + 1) @(posedge clk);
    @(negedge clk);
    check(2'd2, 2'd2, "R10 before window ends");
    @(posedge clk);
    @(negedge clk);
    check(2'd0, 2'd0, "R10 at window end");

    // R11 short request pulse from idle
    begin
      bit moved = 1'b0;
      req_a = 2'd2;
      repeat (STABLE - 1) @(negedge clk);
      req_a = 2'd0;
      for (int k = 0; k < SETTLE + 4; k++) begin
        @(negedge clk);
        if (mode !== 2'd0) moved = 1'b1;
      end
      vectors++;
      if (moved) begin
        miscompares++;
        $display("FAIL R11: short pulse reached outputs, mode=%0d expected 0", mode);
      end
    end

    // R12 reset from active mode
    req_a = 2'd1; set_flags(4'b0000); settle();
    check(2'd2, 2'd1, "R3 before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    req_a = 2'd0;
    check(2'd0, 2'd0, "R12 reset while active");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule